// File: doc/BRIEF.md
# Multiphase Fractional Clock Divider

This block produces a divided clock whose period is an integer number of oscillator cycles plus a fraction in eighths of a cycle. The oscillator offers eight phases 45 degrees apart. In this model those phases are one fast clock, `clk`, that runs eight times the oscillator rate. A free-running 3-bit index names the phase of each fast tick. Edge index k after reset release has phase index k mod 8.

Two counters make the output. The rise counter waits for a target phase and a target count of oscillator cycles, then starts a period. Each period, the target phase moves forward by the fraction. When that phase passes 7 and wraps, one more oscillator cycle is added, so every period lasts exactly 8·N + F fast ticks. The fall counter works on the phase at which the current period started, and ends the high time after a whole number of oscillator cycles. Each period start also gives a one-tick marker, so the length of each period can be measured downstream.

Divide settings are taken only when a period starts. The enable input stops the output cleanly and keeps the phase where it is, so a restart continues the same phase sequence.

Top module: `frac_clk_div`

## Requirements
- R1: For a divide value N ≥ 2 and a fraction F (0..7), successive rising edges of `clk_o` are exactly 8·N + F `clk` cycles apart.
- R2: The rising edge of period i after a start at phase index 0 lands on phase index (i·F) mod 8. After eight periods the elapsed time is exactly 64·N + 8·F ticks.
- R3: `clk_o` stays high for 8·floor(N_eff/2) ticks of each period and is low for the rest. N_eff is the effective divide value.
- R4: `period_start_o` is high for exactly one tick on each rising edge of `clk_o`, and never at any other time.
- R5: `div_int` and `div_frac` are sampled only on the edge that raises `clk_o`. A change made mid-period first changes the length of the period that starts at the next rising edge.
- R6: A divide value of 0 or 1 acts as 2.
- R7: While `srst` is high, `clk_o` and `period_start_o` are low after each edge, the phase index returns to 0, and the next rise phase returns to 0. If `en` is high, the first edge after release raises `clk_o`, so the pulse is seen after edge 0.
- R8: After an edge that samples `en` low, `clk_o` and `period_start_o` are low, and the pending rise phase is held. Once `en` is high again, `clk_o` rises on the first edge whose phase index equals that held phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, eight ticks per oscillator cycle |
| srst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low holds the output low and freezes the phase |
| div_int | input | W | Integer divide value N in oscillator cycles |
| div_frac | input | 3 | Fractional part F in eighths of an oscillator cycle |
| clk_o | output | 1 | Divided clock |
| period_start_o | output | 1 | One-tick marker on each rising edge of `clk_o` |

## Verification
Both outputs are registered, so a rise or fall decided at edge k becomes visible just after edge k. An `en` or `srst` level sampled at edge k clears both outputs just after that same edge. The bench drives inputs and samples outputs 1 ns after each rising edge. It counts edges from reset release, so edge k carries phase index k mod 8, and every expected pulse time is an exact edge number worked out from N and F. A setting written after the sample of edge k is first seen at edge k+1. The mid-period and re-enable cases are placed on edges chosen so that the expected pulse edges can be derived by hand.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  localparam int PH_W   = 3;
  localparam int PH_CNT = 1 << PH_W;

  typedef logic [PH_W-1:0] phase_t;

endpackage

// File: rtl/fcd_phase_gen.sv
// Free-running phase index: the oscillator phase of the current fast tick.
module fcd_phase_gen
  import fcd_pkg::*;
(
  input  logic   clk,
  input  logic   srst,
  output phase_t ph
);

  always_ff @(posedge clk) begin
    if (srst) ph <= '0;
    else      ph <= ph + phase_t'(1);
  end

endmodule

// File: rtl/fcd_rise_ctr.sv
// Counter A: decides rising edges, accumulates the fractional phase and
// latches the divide settings at each period start.
module fcd_rise_ctr
  import fcd_pkg::*;
#(
  parameter int W  = 8,
  localparam int CW = W + 1
) (
  input  logic          clk,
  input  logic          srst,
  input  logic          en,
  input  phase_t        ph,
  input  logic [W-1:0]  div_int,
  input  logic [2:0]    div_frac,
  output logic          rise,
  output logic          run,
  output phase_t        cur_ph,
  output logic [CW-1:0] cyc,
  output logic [CW-1:0] hi_cyc
);

  localparam logic [W-1:0] MIN_DIV = W'(2);

  phase_t        nxt_q;
  logic [CW-1:0] tgt_q;
  logic [W-1:0]  eff_n;
  logic [PH_W:0] sum;
  logic          wrap;

  assign eff_n = (div_int < MIN_DIV) ? MIN_DIV : div_int;
  assign sum   = {1'b0, nxt_q} + {1'b0, div_frac};
  assign wrap  = (ph == phase_t'(PH_CNT - 1));

  assign rise = en && (ph == nxt_q) && (!run || (cyc == tgt_q));

  always_ff @(posedge clk) begin
    if (srst) begin
      run    <= 1'b0;
      nxt_q  <= '0;
      cur_ph <= '0;
      cyc    <= '0;
      tgt_q  <= '0;
      hi_cyc <= '0;
    end else if (!en) begin
      run <= 1'b0;
    end else if (rise) begin
      run    <= 1'b1;
      cur_ph <= ph;
      nxt_q  <= sum[PH_W-1:0];
      tgt_q  <= CW'(eff_n) + CW'(sum[PH_W]);
      hi_cyc <= CW'(eff_n >> 1);
      cyc    <= wrap ? CW'(1) : '0;
    end else if (run) begin
      cyc <= cyc + CW'(wrap);
    end
  end

endmodule

// File: rtl/fcd_fall_ctr.sv
// Counter B: ends the high time on the phase the current period started on.
module fcd_fall_ctr
  import fcd_pkg::*;
#(
  parameter int W  = 8,
  localparam int CW = W + 1
) (
  input  logic          run,
  input  phase_t        ph,
  input  phase_t        cur_ph,
  input  logic [CW-1:0] cyc,
  input  logic [CW-1:0] hi_cyc,
  output logic          fall
);

  always_comb begin
    fall = run && (ph == cur_ph) && (cyc == hi_cyc);
  end

endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div
  import fcd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         srst,
  input  logic         en,
  input  logic [W-1:0] div_int,
  input  logic [2:0]   div_frac,
  output logic         clk_o,
  output logic         period_start_o
);

  localparam int CW = W + 1;

  phase_t        ph;
  phase_t        cur_ph;
  logic          rise;
  logic          fall;
  logic          run;
  logic [CW-1:0] cyc;
  logic [CW-1:0] hi_cyc;

  fcd_phase_gen u_phase (
    .clk  (clk),
    .srst (srst),
    .ph   (ph)
  );

  fcd_rise_ctr #(.W(W)) u_rise (
    .clk      (clk),
    .srst     (srst),
    .en       (en),
    .ph       (ph),
    .div_int  (div_int),
    .div_frac (div_frac),
    .rise     (rise),
    .run      (run),
    .cur_ph   (cur_ph),
    .cyc      (cyc),
    .hi_cyc   (hi_cyc)
  );

  fcd_fall_ctr #(.W(W)) u_fall (
    .run    (run),
    .ph     (ph),
    .cur_ph (cur_ph),
    .cyc    (cyc),
    .hi_cyc (hi_cyc),
    .fall   (fall)
  );

  always_ff @(posedge clk) begin
    if (srst || !en) begin
      clk_o          <= 1'b0;
      period_start_o <= 1'b0;
    end else begin
      period_start_o <= rise;
      if (rise)      clk_o <= 1'b1;
      else if (fall) clk_o <= 1'b0;
    end
  end

endmodule

// File: rtl/fcd_checker.sv
module fcd_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         srst,
  input logic         en,
  input logic [W-1:0] div_int,
  input logic [2:0]   div_frac,
  input logic         clk_o,
  input logic         period_start_o
);

  logic [W-1:0] prev_n;
  logic [2:0]   prev_f;
  int           gap;
  int           exp_len;
  logic         armed;
  int           eff;

  assign eff = (int'(prev_n) < 2) ? 2 : int'(prev_n);

  always_ff @(posedge clk) begin
    prev_n <= div_int;
    prev_f <= div_frac;
    if (srst || !en) begin
      armed <= 1'b0;
      gap   <= 0;
    end else if (period_start_o) begin
      armed   <= 1'b1;
      gap     <= 1;
      exp_len <= 8 * eff + int'(prev_f);
    end else begin
      gap <= gap + 1;
    end
  end

  // R1, R5: period length equals the settings taken at the previous rise
  a_r1_period_len: assert property (@(posedge clk) disable iff (srst || !en)
    (period_start_o && armed) |-> (gap == exp_len));

  a_r4_single_tick: assert property (@(posedge clk) disable iff (srst)
    period_start_o |=> !period_start_o);

  a_r4_marks_rise: assert property (@(posedge clk) disable iff (srst)
    $rose(clk_o) |-> period_start_o);

  a_r4_high_on_mark: assert property (@(posedge clk) disable iff (srst)
    period_start_o |-> clk_o);

  a_r7_reset_quiet: assert property (@(posedge clk)
    srst |=> (!clk_o && !period_start_o));

  a_r8_disable_quiet: assert property (@(posedge clk) disable iff (srst)
    !en |=> (!clk_o && !period_start_o));

endmodule

bind frac_clk_div fcd_checker #(.W(W)) u_chk (
  .clk            (clk),
  .srst           (srst),
  .en             (en),
  .div_int        (div_int),
  .div_frac       (div_frac),
  .clk_o          (clk_o),
  .period_start_o (period_start_o)
);

// File: tb/tb_frac_clk_div.sv
`timescale 1ns/1ps
module tb_frac_clk_div;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         srst = 1'b1;
  logic         en = 1'b0;
  logic [W-1:0] div_int = '0;
  logic [2:0]   div_frac = '0;
  logic         clk_o;
  logic         period_start_o;

  int total = 0;
  int bad   = 0;
  int k     = 0;
  int np;
  int pt [0:15];
  int hc [0:15];
  int r4_bad;

  always #10 clk = ~clk;

  frac_clk_div #(.W(W)) dut (
    .clk            (clk),
    .srst           (srst),
    .en             (en),
    .div_int        (div_int),
    .div_frac       (div_frac),
    .clk_o          (clk_o),
    .period_start_o (period_start_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    k++;
  endtask

  // reset, then k = 0 names the first edge after release
  task automatic do_reset(input int n, input int f, input bit en_v);
    srst = 1'b1;
    en = en_v;
    div_int = W'(n);
    div_frac = 3'(f);
    for (int i = 0; i < 3; i++) begin
      step();
      chk(!clk_o && !period_start_o, "R7 quiet in reset", {clk_o, period_start_o}, 0);
    end
    srst = 1'b0;
    k = 0;
    np = 0;
    r4_bad = 0;
    for (int i = 0; i < 16; i++) begin pt[i] = -1; hc[i] = 0; end
  endtask

  // after each edge: record pulse edges and high ticks per period
  task automatic run_collect(input int steps);
    for (int s = 0; s < steps; s++) begin
      int kn;
      kn = k;
      step();
      if (period_start_o) begin
        if (np < 16) pt[np] = kn;
        np++;
        if (!clk_o) r4_bad++;
      end
      if (clk_o && np > 0 && np <= 16) hc[np-1]++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // sweep: divide values 0..5 (0 and 1 act as 2), every fraction
    for (int n = 0; n < 6; n++) begin
      for (int f = 0; f < 8; f++) begin
        int ne;
        int len;
        ne  = (n < 2) ? 2 : n;
        len = 8 * ne + f;
        do_reset(n, f, 1'b1);
        run_collect(8 * len + 1);
        chk(np == 9, "R1 pulse count", np, 9);
        chk(r4_bad == 0, "R4 marker without high", r4_bad, 0);
        if (np >= 9) begin
          chk(pt[0] == 0, "R7 first rise at edge 0", pt[0], 0);
          for (int i = 1; i < 9; i++) begin
            if (n < 2) chk(pt[i] - pt[i-1] == len, "R6 clamped period", pt[i] - pt[i-1], len);
            else       chk(pt[i] - pt[i-1] == len, "R1 period", pt[i] - pt[i-1], len);
            chk(pt[i] % 8 == (i * f) % 8, "R2 rise phase", pt[i] % 8, (i * f) % 8);
          end
          chk(pt[8] == 64 * ne + 8 * f, "R2 eight periods", pt[8], 64 * ne + 8 * f);
          for (int i = 0; i < 8; i++)
            chk(hc[i] == 8 * (ne / 2), "R3 high time", hc[i], 8 * (ne / 2));
        end
      end
    end

    // R5: change mid-period at edge 10; takes effect from the rise at 26
    do_reset(3, 2, 1'b1);
    run_collect(11);
    div_int = W'(4);
    div_frac = 3'(5);
    run_collect(54);
    chk(np == 3, "R5 pulse count", np, 3);
    chk(pt[1] == 26, "R5 old period kept", pt[1], 26);
    chk(pt[2] == 63, "R5 new period applied", pt[2], 63);

    // R8: disable while high, phase held, restart on the held phase
    do_reset(2, 3, 1'b1);
    run_collect(41);
    chk(np == 3 && pt[2] == 38, "R8 pre-disable rise", pt[2], 38);
    en = 1'b0;
    step();
    chk(!clk_o && !period_start_o, "R8 low after disable", {clk_o, period_start_o}, 0);
    begin
      int seen;
      seen = 0;
      for (int i = 0; i < 29; i++) begin
        step();
        if (clk_o || period_start_o) seen++;
      end
      chk(seen == 0, "R8 quiet while disabled", seen, 0);
    end
    en = 1'b1;
    np = 0;
    run_collect(22);
    chk(np == 2, "R8 pulses after restart", np, 2);
    chk(pt[0] == 73, "R8 restart on held phase", pt[0], 73);
    chk(pt[1] == 92, "R8 period after restart", pt[1], 92);

    // R7: reset mid-run restarts the phase sequence at 0
    do_reset(5, 7, 1'b1);
    run_collect(30);
    do_reset(3, 1, 1'b1);
    run_collect(27);
    chk(np == 2 && pt[0] == 0, "R7 restart at phase 0", pt[0], 0);
    chk(pt[1] == 25, "R7 period after reset", pt[1], 25);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule